// File: doc/BRIEF.md
# Memory-Mapped GPIO with Interrupt Detection

A 32-pin general-purpose I/O block sitting on a simple word-wide register bus. Software owns an output data register, which it can write whole or change bit by bit through separate set and clear ports. A direction register selects which pins are driven. Every pin's input passes through a two-flop synchroniser and an optional debounce filter. The filtered value is readable and feeds the interrupt logic.

The interrupt logic is configured per pin through three bit-per-pin registers. A type bit selects edge or level detection. A polarity bit selects rising/high or falling/low. A both-edges bit makes edge mode fire on every transition. Edge events are latched and cleared by write-one-to-clear; level status follows the qualified input directly. An enable register gates whether a pin may raise status at all. A mask register keeps status off the single combined interrupt output without stopping it from being recorded. Pull control registers are only stored.

Debounce is a per-pin two-state machine. DB_STABLE holds the accepted value. Transition DIFFER leaves it for DB_SETTLE when the synchronised input differs from the accepted value. In DB_SETTLE, transition MATCH returns to DB_STABLE when the input falls back to the accepted value, and transition ACCEPT takes the new value and returns to DB_STABLE when the input has differed for prescale+1 divided-clock ticks. With debounce off, the state stays DB_STABLE and the accepted value follows the synchroniser every cycle.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads zero, no pin is driven (`pin_oe` = 0), and `irq_out` is 0.
- R2: A write to offset 0x00 loads the output data register, which appears on `pin_out` and reads back at 0x00. A write to 0x08 loads the direction register, which appears on `pin_oe` (1 = driven) and reads back at 0x08.
- R3: A write to 0x10 ORs the written ones into the output data register, and a write to 0x14 clears the bits written as one; zero bits leave pins unchanged. Reads of 0x10, 0x14 and 0x30 return zero.
- R4: Offset 0x04 returns the filtered pin inputs after a two-flop synchroniser; without debounce a pin change is readable three clock edges later.
- R5: With a type bit (0x34) of 0 the pin is edge-detected: a polarity bit (0x3C) of 0 selects rising edges and 1 selects falling edges; the status register is at 0x24, one bit per pin.
- R6: With a both-edges bit (0x38) of 1 in edge mode, every transition sets status and the polarity bit is ignored.
- R7: Edge status stays latched until a one is written to the matching bit of 0x30; zero bits leave other pending bits set.
- R8: With a type bit of 1 the status bit follows the level (high when polarity 0, low when polarity 1) and is not latched; a clear write has no effect while the level is active.
- R9: A pin whose interrupt enable bit (0x20) is 0 raises no status.
- R10: A mask bit (0x2C) of 1 keeps the pin's status off `irq_out` while the status is still recorded; `irq_out` is 1 when any unmasked status bit is 1.
- R11: With a debounce enable bit (0x40) of 1, a new input value is accepted only after it stays stable for prescale (0x44, low 8 bits) + 1 ticks, one tick every TICK_DIV clock cycles; shorter pulses are ignored.
- R12: Pull enable (0x18) and pull type (0x1C) are stored and read back with no effect on the pins; unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| pin_in | input | 32 | Raw pin inputs |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench exercises the set and clear ports with zero words. A design that treats zero bits as writes would corrupt unrelated pins. It checks that a falling edge is ignored under rising polarity, and that both-edges mode fires against the polarity bit. It also clears a level-mode pin while its level is held, where a latching design would wrongly drop the bit. A two-cycle glitch is sent through an enabled debounce filter, and a held change is sampled before its tick count is reached and after it. A filter that skipped the tick count would accept the glitch or accept the change too early.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GP_AW = 8;
    localparam int GP_DW = 32;

    localparam logic [GP_AW-1:0] OFS_DOUT   = 8'h00;
    localparam logic [GP_AW-1:0] OFS_DIN    = 8'h04;
    localparam logic [GP_AW-1:0] OFS_DIR    = 8'h08;
    localparam logic [GP_AW-1:0] OFS_SET    = 8'h10;
    localparam logic [GP_AW-1:0] OFS_CLR    = 8'h14;
    localparam logic [GP_AW-1:0] OFS_PULLEN = 8'h18;
    localparam logic [GP_AW-1:0] OFS_PULLTY = 8'h1C;
    localparam logic [GP_AW-1:0] OFS_IEN    = 8'h20;
    localparam logic [GP_AW-1:0] OFS_ISTAT  = 8'h24;
    localparam logic [GP_AW-1:0] OFS_IMASK  = 8'h2C;
    localparam logic [GP_AW-1:0] OFS_IACK   = 8'h30;
    localparam logic [GP_AW-1:0] OFS_ITYPE  = 8'h34;
    localparam logic [GP_AW-1:0] OFS_IBOTH  = 8'h38;
    localparam logic [GP_AW-1:0] OFS_IPOL   = 8'h3C;
    localparam logic [GP_AW-1:0] OFS_DBEN   = 8'h40;
    localparam logic [GP_AW-1:0] OFS_DBPRE  = 8'h44;

    typedef enum logic [0:0] {
        DB_STABLE = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_t;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             deb_en,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre,
    output logic             filt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s;
    db_state_t              state, state_nx;
    logic [PRE_W-1:0]       cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end
    assign s = sync_q[SYNC_STAGES-1];

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            DB_STABLE: if (deb_en && (s != filt)) state_nx = DB_SETTLE;          // DIFFER
            DB_SETTLE: begin
                if (!deb_en || (s == filt))       state_nx = DB_STABLE;          // MATCH
                else if (tick && (cnt == pre))    state_nx = DB_STABLE;          // ACCEPT
            end
            default:                              state_nx = DB_STABLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DB_STABLE;
        else        state <= state_nx;
    end

    // datapath: counter and accepted value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (!deb_en) begin
            cnt  <= '0;
            filt <= s;
        end else begin
            unique case (state)
                DB_STABLE: cnt <= '0;
                DB_SETTLE: begin
                    if (s == filt) cnt <= '0;
                    else if (tick) begin
                        if (cnt == pre) begin
                            filt <= s;
                            cnt  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R11
    deb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(deb_en) && !$past(tick)) |-> $stable(filt));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] filt,
    input  logic [DW-1:0] en,
    input  logic [DW-1:0] typ,
    input  logic [DW-1:0] pol,
    input  logic [DW-1:0] both,
    input  logic          ack_wr,
    input  logic [DW-1:0] ack_bits,
    output logic [DW-1:0] stat
);
    logic [DW-1:0] prev, rise, fall, edge_evt, edge_q, lvl_stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= filt;
    end

    assign rise = filt & ~prev;
    assign fall = ~filt & prev;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            logic hit;
            if (both[i]) hit = rise[i] | fall[i];
            else if (pol[i]) hit = fall[i];
            else hit = rise[i];
            edge_evt[i] = en[i] & ~typ[i] & hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= (edge_q & ~(ack_wr ? ack_bits : '0)) | edge_evt;
    end

    assign lvl_stat = en & typ & (filt ^ pol);
    assign stat     = (typ & lvl_stat) | (~typ & edge_q);

    // R9
    edge_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_q & ~$past(edge_q) & ~$past(en)) == '0));

    // R7
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_wr) |-> ((edge_q & $past(edge_q)) == $past(edge_q)));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [GP_AW-1:0] bus_addr,
    input  logic [GP_DW-1:0] bus_wdata,
    output logic [GP_DW-1:0] bus_rdata,
    input  logic [GP_DW-1:0] pin_in,
    output logic [GP_DW-1:0] pin_out,
    output logic [GP_DW-1:0] pin_oe,
    output logic             irq_out
);
    localparam int DW = GP_DW;

    logic [DW-1:0] dout_q, dir_q, pullen_q, pullty_q;
    logic [DW-1:0] ien_q, imask_q, itype_q, iboth_q, ipol_q, dben_q;
    logic [PRE_W-1:0] dbpre_q;
    logic [DW-1:0] filt, stat;
    logic tick, wr, ack_wr;

    assign wr     = bus_sel & bus_wr;
    assign ack_wr = wr && (bus_addr == OFS_IACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0; dir_q <= '0; pullen_q <= '0; pullty_q <= '0;
            ien_q <= '0; imask_q <= '0; itype_q <= '0; iboth_q <= '0;
            ipol_q <= '0; dben_q <= '0; dbpre_q <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_DOUT:   dout_q   <= bus_wdata;
                OFS_SET:    dout_q   <= dout_q | bus_wdata;
                OFS_CLR:    dout_q   <= dout_q & ~bus_wdata;
                OFS_DIR:    dir_q    <= bus_wdata;
                OFS_PULLEN: pullen_q <= bus_wdata;
                OFS_PULLTY: pullty_q <= bus_wdata;
                OFS_IEN:    ien_q    <= bus_wdata;
                OFS_IMASK:  imask_q  <= bus_wdata;
                OFS_ITYPE:  itype_q  <= bus_wdata;
                OFS_IBOTH:  iboth_q  <= bus_wdata;
                OFS_IPOL:   ipol_q   <= bus_wdata;
                OFS_DBEN:   dben_q   <= bus_wdata;
                OFS_DBPRE:  dbpre_q  <= bus_wdata[PRE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_DOUT:   bus_rdata = dout_q;
                OFS_DIN:    bus_rdata = filt;
                OFS_DIR:    bus_rdata = dir_q;
                OFS_PULLEN: bus_rdata = pullen_q;
                OFS_PULLTY: bus_rdata = pullty_q;
                OFS_IEN:    bus_rdata = ien_q;
                OFS_ISTAT:  bus_rdata = stat;
                OFS_IMASK:  bus_rdata = imask_q;
                OFS_ITYPE:  bus_rdata = itype_q;
                OFS_IBOTH:  bus_rdata = iboth_q;
                OFS_IPOL:   bus_rdata = ipol_q;
                OFS_DBEN:   bus_rdata = dben_q;
                OFS_DBPRE:  bus_rdata = DW'(dbpre_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    gpio_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar g = 0; g < DW; g++) begin : g_pin
        gpio_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .PRE_W(PRE_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin_raw(pin_in[g]), .deb_en(dben_q[g]),
            .tick(tick), .pre(dbpre_q), .filt(filt[g])
        );
    end

    gpio_irq_detect #(.DW(DW)) u_det (
        .clk(clk), .rst_n(rst_n), .filt(filt), .en(ien_q), .typ(itype_q),
        .pol(ipol_q), .both(iboth_q), .ack_wr(ack_wr), .ack_bits(bus_wdata),
        .stat(stat)
    );

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign irq_out = |(stat & ~imask_q);

    // R3
    set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    // R10
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&imask_q) |-> !irq_out);
endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
    logic        irq_out;
    int          checks = 0, errors = 0;

    gpio_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    localparam int NV = 6;
    localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h10, 8'h14, 8'h10, 8'h14, 8'h00};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0000, 32'h0000_00FF, 32'hA000_000F,
                                            32'h0, 32'h0, 32'h1234_5678};
    localparam logic [31:0] V_EXP  [NV] = '{32'hA5A5_0000, 32'hA5A5_00FF, 32'h05A5_00F0,
                                            32'h05A5_00F0, 32'h05A5_00F0, 32'h1234_5678};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        waitc(3);
        rst_n = 1;
        waitc(2);

        // R1 reset state
        for (int a = 0; a <= 'h44; a += 4) begin
            bread(8'(a), r);
            chk("R1 reset register", r, 32'h0);
        end
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq", {31'h0, irq_out}, 32'h0);

        // R2 R3 vector table
        for (int i = 0; i < NV; i++) begin
            bwrite(V_ADDR[i], V_DATA[i]);
            bread(8'h00, r);
            chk("R2/R3 data out readback", r, V_EXP[i]);
            chk("R2/R3 pin_out", pin_out, V_EXP[i]);
        end
        bread(8'h10, r); chk("R3 set port reads zero", r, 0);
        bread(8'h14, r); chk("R3 clear port reads zero", r, 0);
        bread(8'h30, r); chk("R3 ack port reads zero", r, 0);
        bwrite(8'h08, 32'h0F0F_00FF);
        chk("R2 pin_oe", pin_oe, 32'h0F0F_00FF);
        bread(8'h08, r); chk("R2 dir readback", r, 32'h0F0F_00FF);

        // R12 pull registers and unmapped
        bwrite(8'h18, 32'hDEAD_BEEF);
        bwrite(8'h1C, 32'h1234_0000);
        bread(8'h18, r); chk("R12 pull enable", r, 32'hDEAD_BEEF);
        bread(8'h1C, r); chk("R12 pull type", r, 32'h1234_0000);
        chk("R12 pins unaffected", pin_out, 32'h1234_5678);
        bwrite(8'h0C, 32'hFFFF_FFFF);
        bread(8'h0C, r); chk("R12 unmapped 0x0C", r, 0);
        bwrite(8'h48, 32'hFFFF_FFFF);
        bread(8'h48, r); chk("R12 unmapped 0x48", r, 0);

        // R4 input sync timing
        pin_in = 32'h0000_0100;
        @(negedge clk); #1 bus_sel = 1; bus_addr = 8'h04;
        @(negedge clk); #1 chk("R4 not yet visible after 2 edges", bus_rdata, 0);
        @(negedge clk); #1 chk("R4 visible after 3 edges", bus_rdata, 32'h0000_0100);
        bus_sel = 0;
        pin_in = 0; waitc(4);

        // R5 rising edge on pin0
        bwrite(8'h20, 32'h0000_0003);
        pin_in[0] = 1; waitc(6);
        bread(8'h24, r); chk("R5 rising sets status", r, 32'h1);
        chk("R10 irq asserted", {31'h0, irq_out}, 32'h1);
        // R7 zero bits do not clear
        bwrite(8'h30, 32'hFFFF_FFFE);
        bread(8'h24, r); chk("R7 zero bit keeps status", r, 32'h1);
        bwrite(8'h30, 32'h1);
        bread(8'h24, r); chk("R7 ack clears", r, 32'h0);
        pin_in[0] = 0; waitc(6);
        bread(8'h24, r); chk("R5 falling ignored with rising polarity", r, 32'h0);
        bwrite(8'h3C, 32'h1);
        pin_in[0] = 1; waitc(6);
        bread(8'h24, r); chk("R5 rising ignored with falling polarity", r, 32'h0);
        pin_in[0] = 0; waitc(6);
        bread(8'h24, r); chk("R5 falling sets status", r, 32'h1);
        bwrite(8'h30, 32'h1);

        // R6 both-edges overrides polarity (polarity still falling)
        bwrite(8'h38, 32'h1);
        pin_in[0] = 1; waitc(6);
        bread(8'h24, r); chk("R6 rising in both-edge mode", r, 32'h1);
        bwrite(8'h30, 32'h1);
        pin_in[0] = 0; waitc(6);
        bread(8'h24, r); chk("R6 falling in both-edge mode", r, 32'h1);
        bwrite(8'h30, 32'h1);

        // R8 level mode on pin1, active high
        bwrite(8'h34, 32'h2);
        pin_in[1] = 1; waitc(4);
        bread(8'h24, r); chk("R8 level high status", r, 32'h2);
        bwrite(8'h30, 32'h2);
        bread(8'h24, r); chk("R8 clear ineffective while active", r, 32'h2);
        pin_in[1] = 0; waitc(4);
        bread(8'h24, r); chk("R8 status follows level down", r, 32'h0);
        bwrite(8'h3C, 32'h2);
        waitc(2);
        bread(8'h24, r); chk("R8 active-low level", r, 32'h2);
        bwrite(8'h20, 32'h1);
        bread(8'h24, r); chk("R9 level gated by enable", r, 32'h0);

        // R9 enable off for pin2
        pin_in[2] = 1; waitc(6);
        pin_in[2] = 0; waitc(6);
        bread(8'h24, r); chk("R9 disabled pin raises no status", r, 32'h0);
        chk("R9 irq low", {31'h0, irq_out}, 32'h0);

        // R10 mask
        bwrite(8'h3C, 32'h0);
        bwrite(8'h2C, 32'h1);
        pin_in[0] = 1; waitc(6);
        bread(8'h24, r); chk("R10 masked status recorded", r, 32'h1);
        chk("R10 masked irq low", {31'h0, irq_out}, 32'h0);
        bwrite(8'h2C, 32'h0);
        chk("R10 unmask raises irq", {31'h0, irq_out}, 32'h1);
        bwrite(8'h30, 32'hFFFF_FFFF);
        chk("R10 irq low after ack", {31'h0, irq_out}, 32'h0);

        // R11 debounce on pin3, prescale 3 -> 4 ticks of 4 cycles
        bwrite(8'h44, 32'h3);
        bwrite(8'h40, 32'h8);
        pin_in[3] = 1; waitc(2); pin_in[3] = 0;
        waitc(40);
        bread(8'h04, r); chk("R11 glitch rejected", r & 32'h8, 32'h0);
        pin_in[3] = 1; waitc(6);
        bread(8'h04, r); chk("R11 not accepted early", r & 32'h8, 32'h0);
        waitc(34);
        bread(8'h04, r); chk("R11 accepted after hold", r & 32'h8, 32'h8);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule